// File: doc/BRIEF.md
# CAN Interrupt Identifier Arbiter

This block sits between the interrupt sources of a CAN controller and the CPU. It takes one pending flag from each message object and an event pulse from the controller's status logic, and presents a single identifier code that names the most urgent source still pending. It drives one interrupt line, which stays high while any enabled source is pending. Software services the source named by the code, clears it, and reads the code again. It leaves its service routine only when the code reads zero.

The status-change source is held inside the block. An event pulse sets it. A read that covers the status byte clears it, whether that read is a byte access or a 16-bit access. A read of the control byte alone leaves it pending. Each object flag is a level driven by its message object, and it drops when software clears that object's pending bit. The identifier is recomputed every cycle. A cleared source therefore gives way to the next one at once, and a newly raised source of higher rank displaces the one shown.

The last message object works as a catch-all receive buffer. It ranks just below the status source. Objects 1 to NUM_OBJ-1 follow in ascending order.

Top module: `can_irq_arbiter`

## Requirements
- R1: After reset, the identifier is 00h, the interrupt line is low and no status-change source is pending.
- R2: When no enabled source is pending, the identifier is 00h.
- R3: A lower identifier has higher priority. The ranking is: status change = 01h; message object NUM_OBJ = 02h; message object k for 1 <= k < NUM_OBJ = k+2 (object 1 = 03h, object 14 = 10h). Object k is input bit obj_pend[k-1].
- R4: When object NUM_OBJ (input bit NUM_OBJ-1) is the highest pending enabled source, the identifier is 02h.
- R5: Clearing the source shown makes the next pending source appear. Raising a source of higher rank replaces the one shown.
- R6: A read strobe with rd_lanes[1] set clears the pending status-change source. This covers a status-byte read (rd_lanes = 10b) and a 16-bit read (rd_lanes = 11b). A control-byte-only read (rd_lanes = 01b) does not clear it.
- R7: If a status event and a clearing status read arrive in the same cycle, the status-change source stays pending.
- R8: The status-change source reports only when both glb_ie and stat_ie are 1. Object sources need only glb_ie. A pending status change that is masked is kept, and it reports once both enables are 1.
- R9: The interrupt line is high exactly when the identifier is non-zero.
- R10: The identifier and the line are registered. A change of any source, strobe or enable takes effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| obj_pend | input | NUM_OBJ | Pending flag of each message object; bit k-1 is object k |
| stat_evt | input | 1 | One-cycle pulse that sets the status-change source |
| rd_stb | input | 1 | Register read strobe |
| rd_lanes | input | 2 | Byte lanes of the read: bit 1 status byte, bit 0 control byte |
| glb_ie | input | 1 | Global interrupt enable |
| stat_ie | input | 1 | Status-change interrupt enable |
| int_id | output | ID_W | Identifier of the highest-priority pending source, 00h if none |
| irq | output | 1 | Interrupt line to the CPU |

## Verification
A status event and a status-byte read can land in the same cycle. One would set the status-change source and the other would clear it. The bench provokes this by pulsing the event together with a read on the status lane. It expects identifier 01h on the next edge, and it then confirms that a later plain read removes the code. The second pair is an object source clearing while a higher-ranked source rises. The bench drops the shown object and raises the status event in one cycle, and it judges the identifier against the priority order one edge later.

// File: rtl/can_irq_arbiter.sv
module can_irq_arbiter #(
  parameter int NUM_OBJ = 15,
  parameter int ID_W    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_OBJ-1:0] obj_pend,
  input  logic               stat_evt,
  input  logic               rd_stb,
  input  logic [1:0]         rd_lanes,
  input  logic               glb_ie,
  input  logic               stat_ie,
  output logic [ID_W-1:0]    int_id,
  output logic               irq
);

  localparam int TOP_OBJ = NUM_OBJ - 1;
  localparam logic [ID_W-1:0] ID_STAT = ID_W'(1);
  localparam logic [ID_W-1:0] ID_TOP  = ID_W'(2);

  logic            stat_pend;
  logic            stat_clr;
  logic            stat_nxt;
  logic [ID_W-1:0] id_nxt;

  assign stat_clr = rd_stb & rd_lanes[1];
  // a fresh event outranks a read in the same cycle (R7)
  assign stat_nxt = stat_evt | (stat_pend & ~stat_clr);

  always_comb begin
    id_nxt = '0;
    if (glb_ie) begin
      for (int k = TOP_OBJ; k >= 1; k--)
        if (obj_pend[k-1]) id_nxt = ID_W'(k + 2);
      if (obj_pend[TOP_OBJ]) id_nxt = ID_TOP;
      if (stat_ie && stat_nxt) id_nxt = ID_STAT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_pend <= 1'b0;
      int_id    <= '0;
      irq       <= 1'b0;
    end else begin
      stat_pend <= stat_nxt;
      int_id    <= id_nxt;
      irq       <= (id_nxt != '0);
    end
  end

endmodule

// File: rtl/can_irq_arbiter_chk.sv
module can_irq_arbiter_chk #(
  parameter int NUM_OBJ = 15,
  parameter int ID_W    = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_OBJ-1:0] obj_pend,
  input logic               stat_evt,
  input logic               rd_stb,
  input logic [1:0]         rd_lanes,
  input logic               glb_ie,
  input logic               stat_ie,
  input logic [ID_W-1:0]    int_id,
  input logic               irq,
  input logic               stat_pend
);

  a_r2_masked_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_ie |=> int_id == '0);

  a_r9_line_matches_id: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (int_id != '0));

  a_r6_status_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && rd_lanes[1] && !stat_evt |=> !stat_pend);

  a_r6_ctrl_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    stat_pend && rd_stb && rd_lanes == 2'b01 |=> stat_pend);

  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    stat_evt |=> stat_pend);

  a_r3_status_first: assert property (@(posedge clk) disable iff (!rst_n)
    glb_ie && stat_ie && stat_evt |=> int_id == ID_W'(1));

  a_r4_top_object: assert property (@(posedge clk) disable iff (!rst_n)
    glb_ie && obj_pend[NUM_OBJ-1] && !(stat_ie && (stat_evt || (stat_pend && !(rd_stb && rd_lanes[1]))))
    |=> int_id == ID_W'(2));

endmodule

bind can_irq_arbiter can_irq_arbiter_chk #(.NUM_OBJ(NUM_OBJ), .ID_W(ID_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .obj_pend(obj_pend), .stat_evt(stat_evt),
  .rd_stb(rd_stb), .rd_lanes(rd_lanes), .glb_ie(glb_ie), .stat_ie(stat_ie),
  .int_id(int_id), .irq(irq), .stat_pend(stat_pend)
);

// File: tb/can_irq_arbiter_tb_top.sv
module can_irq_arbiter_tb_top;
  localparam int NUM_OBJ = 15;
  localparam int ID_W    = 8;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NUM_OBJ-1:0] obj_pend = '0;
  logic               stat_evt = 1'b0;
  logic               rd_stb = 1'b0;
  logic [1:0]         rd_lanes = 2'b00;
  logic               glb_ie = 1'b0;
  logic               stat_ie = 1'b0;
  logic [ID_W-1:0]    int_id;
  logic               irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  can_irq_arbiter #(.NUM_OBJ(NUM_OBJ), .ID_W(ID_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .obj_pend(obj_pend), .stat_evt(stat_evt),
    .rd_stb(rd_stb), .rd_lanes(rd_lanes), .glb_ie(glb_ie), .stat_ie(stat_ie),
    .int_id(int_id), .irq(irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [ID_W-1:0] exp);
    n_tests++;
    if (int_id !== exp || irq !== (exp != '0)) begin
      n_fail++;
      $display("FAIL %s: id=%02h irq=%b expected id=%02h irq=%b",
               req, int_id, irq, exp, exp != '0);
    end
  endtask

  task automatic status_read(input logic [1:0] lanes);
    rd_stb = 1'b1; rd_lanes = lanes;
    tick();
    rd_stb = 1'b0; rd_lanes = 2'b00;
  endtask

  task automatic pulse_evt();
    stat_evt = 1'b1;
    tick();
    stat_evt = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 reset", 8'h00);
    rst_n = 1'b1;
    tick();
    chk("R2 idle", 8'h00);
    glb_ie = 1'b1; stat_ie = 1'b1;
    tick();
    chk("R1 no status pending after reset", 8'h00);
  endtask

  task automatic t_each_object();
    for (int k = 1; k <= NUM_OBJ; k++) begin
      obj_pend = '0;
      obj_pend[k-1] = 1'b1;
      tick();
      if (k == NUM_OBJ) chk("R4 top object", 8'h02);
      else chk("R3 single object", ID_W'(k + 2));
    end
    obj_pend = '0;
    tick();
    chk("R2 all cleared", 8'h00);
  endtask

  task automatic t_drain_order();
    obj_pend = '1;
    pulse_evt();
    chk("R3 status wins", 8'h01);
    status_read(2'b10);
    chk("R5 next after status cleared", 8'h02);
    obj_pend[NUM_OBJ-1] = 1'b0;
    tick();
    chk("R5 object 1 after top cleared", 8'h03);
    for (int k = 1; k < NUM_OBJ - 1; k++) begin
      obj_pend[k-1] = 1'b0;
      tick();
      chk("R5 drain step", ID_W'(k + 3));
    end
    obj_pend[NUM_OBJ-2] = 1'b0;
    tick();
    chk("R2 drained", 8'h00);
  endtask

  task automatic t_preempt();
    obj_pend = '0;
    obj_pend[9] = 1'b1;
    tick();
    chk("R3 object 10", 8'h0C);
    obj_pend[2] = 1'b1;
    tick();
    chk("R5 higher object replaces", 8'h05);
    obj_pend[NUM_OBJ-1] = 1'b1;
    tick();
    chk("R4 top object replaces", 8'h02);
    obj_pend[NUM_OBJ-1] = 1'b0;
    stat_evt = 1'b1;
    tick();
    stat_evt = 1'b0;
    chk("R5 clear and raise same cycle", 8'h01);
    status_read(2'b10);
    chk("R5 back to object 3", 8'h05);
    obj_pend = '0;
    tick();
    chk("R10 one edge after clear", 8'h00);
  endtask

  task automatic t_status_reads();
    pulse_evt();
    chk("R10 event seen at next edge", 8'h01);
    status_read(2'b01);
    chk("R6 control byte read keeps status", 8'h01);
    status_read(2'b10);
    chk("R6 status byte read clears", 8'h00);
    pulse_evt();
    status_read(2'b11);
    chk("R6 word read clears", 8'h00);
    stat_evt = 1'b1; rd_stb = 1'b1; rd_lanes = 2'b10;
    tick();
    stat_evt = 1'b0; rd_stb = 1'b0; rd_lanes = 2'b00;
    chk("R7 event and read same cycle", 8'h01);
    tick();
    chk("R7 still pending", 8'h01);
    status_read(2'b10);
    chk("R7 later read clears", 8'h00);
  endtask

  task automatic t_enables();
    stat_ie = 1'b0;
    pulse_evt();
    chk("R8 status masked by stat_ie", 8'h00);
    obj_pend[2] = 1'b1;
    tick();
    chk("R8 object needs only global", 8'h05);
    stat_ie = 1'b1;
    tick();
    chk("R8 masked status kept", 8'h01);
    glb_ie = 1'b0;
    tick();
    chk("R8 global off masks all", 8'h00);
    glb_ie = 1'b1;
    tick();
    chk("R8 global back on", 8'h01);
    status_read(2'b10);
    obj_pend = '0;
    tick();
    chk("R9 line low when id zero", 8'h00);
  endtask

  initial begin
    t_reset();
    t_each_object();
    t_drain_order();
    t_preempt();
    t_status_reads();
    t_enables();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule